// File: doc/BRIEF.md
# Multicycle Instruction Cycle Controller

This block sequences a small accumulator machine. Each step is a single register transfer, and one step takes one clock. The block holds the program counter, a memory address register, a memory buffer register, an instruction register and one accumulator. A fetch takes three steps. An indirect pass, taken only when the instruction asks for it, takes three steps and replaces the address field of the instruction with the word it points to. Execute takes between one and three steps depending on the opcode. After every instruction the block checks a single interrupt request. If the request is taken, a three-step interrupt pass stores the return address at a fixed save location and continues at a fixed routine address.

The block drives a single-port memory with synchronous read. It presents an address and a read strobe in one cycle and expects the word on `mem_rdata` throughout the next cycle. The step that captures a read word loads it into the buffer register. A fetch loads the same word into the instruction register in that step as well. Writes use the address, write data and write strobe of one cycle. The accumulator and program counter are brought out so that the surrounding logic can observe them.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: While reset is low, `pc` is 0, `acc` is 0, `halted` is 0 and neither strobe is high. The first fetch after reset reads address 0.
- R2: A fetch takes three cycles. The read strobe is high in the second cycle with `mem_addr` equal to the program counter, and `pc` has increased by one in the third cycle.
- R3: An instruction word holds the opcode in bits 15:13, the indirect flag in bit 12 and an address in bits 11:0. The opcodes are 000 halt, 001 load, 010 store, 011 add and 100 jump. Opcodes 101 to 111 run a one-cycle execute step that changes nothing.
- R4: Load sets `acc` to the memory word at the address. Add sets `acc` to `acc` plus that word, modulo 2^16.
- R5: Store writes `acc` to the address with one write strobe.
- R6: Jump loads the address into the program counter.
- R7: When bit 12 is set, the effective address is bits 11:0 of the word at the address field. This indirect pass adds three cycles.
- R8: An interrupt enable bit is set by reset. When `irq` is high and the enable bit is set at the end of an instruction, the program counter is written to SAVE_ADDR, execution continues at ISR_ADDR and the enable bit clears, so a request that stays high is not taken again.
- R9: After a halt instruction, `halted` stays high, `pc` stays constant and no strobe is issued until reset.
- R10: The read strobe and the write strobe are never high in the same cycle.
- R11: Counted from the first clock after reset, a load, add or store without indirection takes six cycles and a jump takes four. A halt instruction raises `halted` after its three fetch cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt request, checked at the end of each instruction |
| mem_addr | output | AW | Memory address, driven from the address register |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| mem_rdata | input | 16 | Read data, valid in the cycle after the read strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| acc | output | 16 | Accumulator |
| pc | output | AW | Program counter |
| halted | output | 1 | High once a halt instruction has been fetched |

## Verification
The assertions assume that `mem_rdata` holds the word addressed in the previous cycle whenever a read strobe was issued. They also assume that `irq` is sampled only at clock edges. The bench memory model is a registered array that updates `mem_rdata` on the same edge that ends the strobe cycle. The bench drives `irq` and reset only at falling edges, so both inputs stay within these assumptions. Every program the bench runs ends in a halt instruction, so the sequencer always reaches a state the bench can observe.

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl #(
  parameter int AW = 12,
  parameter logic [AW-1:0] SAVE_ADDR = 'h3F0,
  parameter logic [AW-1:0] ISR_ADDR  = 'h200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [15:0]   acc,
  output logic [AW-1:0] pc,
  output logic          halted
);
  localparam int OPW = 3;
  localparam int DW  = 16;

  localparam logic [OPW-1:0] OP_HALT  = 3'd0;
  localparam logic [OPW-1:0] OP_LOAD  = 3'd1;
  localparam logic [OPW-1:0] OP_STORE = 3'd2;
  localparam logic [OPW-1:0] OP_ADD   = 3'd3;
  localparam logic [OPW-1:0] OP_JMP   = 3'd4;

  typedef enum logic [3:0] {
    S_F1, S_F2, S_F3, S_I1, S_I2, S_I3, S_E1, S_E2, S_E3,
    S_N1, S_N2, S_N3, S_HALT
  } step_t;

  step_t          st;
  logic [AW-1:0]  pc_q, mar_q;
  logic [DW-1:0]  mbr_q, ir_q, acc_q;
  logic           ie_q;

  wire [OPW-1:0] op     = ir_q[DW-1 -: OPW];
  wire [AW-1:0]  fld    = ir_q[AW-1:0];
  wire [OPW-1:0] op_in  = mem_rdata[DW-1 -: OPW];
  wire           is_mem = (op == OP_LOAD) || (op == OP_ADD);
  wire           is_st  = (op == OP_STORE);
  step_t         after_ex;

  assign after_ex  = (irq && ie_q) ? S_N1 : S_F1;
  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign mem_rd    = (st == S_F2) || (st == S_I2) || (st == S_E2 && is_mem);
  assign mem_wr    = (st == S_E2 && is_st) || (st == S_N3);
  assign acc       = acc_q;
  assign pc        = pc_q;
  assign halted    = (st == S_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_F1;
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      ie_q  <= 1'b1;
    end else begin
      case (st)
        S_F1: begin mar_q <= pc_q; st <= S_F2; end
        S_F2: begin pc_q <= pc_q + 1'b1; st <= S_F3; end
        S_F3: begin
          mbr_q <= mem_rdata;
          ir_q  <= mem_rdata;
          if (op_in == OP_HALT)   st <= S_HALT;
          else if (mem_rdata[AW]) st <= S_I1;
          else                    st <= S_E1;
        end
        S_I1: begin mar_q <= fld; st <= S_I2; end
        S_I2: st <= S_I3;
        S_I3: begin
          mbr_q          <= mem_rdata;
          ir_q[AW-1:0]   <= mem_rdata[AW-1:0];
          st             <= S_E1;
        end
        S_E1: begin
          if (is_mem) begin
            mar_q <= fld;
            st    <= S_E2;
          end else if (is_st) begin
            mar_q <= fld;
            mbr_q <= acc_q;
            st    <= S_E2;
          end else if (op == OP_JMP) begin
            pc_q <= fld;
            st   <= after_ex;
          end else begin
            st <= after_ex;
          end
        end
        S_E2: st <= S_E3;
        S_E3: begin
          if (is_mem) mbr_q <= mem_rdata;
          if (op == OP_LOAD)     acc_q <= mem_rdata;
          else if (op == OP_ADD) acc_q <= acc_q + mem_rdata;
          st <= after_ex;
        end
        S_N1: begin mbr_q <= {{(DW-AW){1'b0}}, pc_q}; st <= S_N2; end
        S_N2: begin
          mar_q <= SAVE_ADDR;
          pc_q  <= ISR_ADDR;
          ie_q  <= 1'b0;
          st    <= S_N3;
        end
        S_N3: st <= S_F1;
        default: st <= S_HALT;
      endcase
    end
  end

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_F2) |=> (pc_q == $past(pc_q) + AW'(1)));

  a_r6_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_E1 && op == OP_JMP) |=> (pc_q == $past(fld)));

  a_r8_enter_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_N2) |=> (!ie_q && pc_q == ISR_ADDR && mem_addr == SAVE_ADDR));

  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc_q) && !mem_rd && !mem_wr));
endmodule

// File: tb/tb_instr_cycle_ctrl.sv
module tb_instr_cycle_ctrl;
  localparam int AW = 12;
  localparam logic [AW-1:0] SAVE = 12'h3F0;
  localparam logic [AW-1:0] ISR  = 12'h200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 1'b0;
  logic [AW-1:0] mem_addr, pc;
  logic [15:0] mem_wdata, acc;
  logic [15:0] mem_rdata = '0;
  logic mem_rd, mem_wr, halted;

  int tests = 0;
  int fails = 0;
  int strobes = 0;
  logic [15:0] mem [0:1023];

  always #10 clk = ~clk;

  instr_cycle_ctrl #(.AW(AW), .SAVE_ADDR(SAVE), .ISR_ADDR(ISR)) dut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .acc(acc), .pc(pc), .halted(halted));

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_rd || mem_wr) strobes <= strobes + 1;
  end

  // {a, b, a+b mod 2^16}
  localparam logic [47:0] VEC [6] = '{
    {16'h0000, 16'h0000, 16'h0000},
    {16'h0001, 16'h0002, 16'h0003},
    {16'hFFFF, 16'h0001, 16'h0000},
    {16'h8000, 16'h8000, 16'h0000},
    {16'h1234, 16'h4321, 16'h5555},
    {16'h7FFF, 16'h0001, 16'h8000}
  };

  function automatic logic [15:0] ins(logic [2:0] op, logic ind, logic [11:0] a);
    return {op, ind, a};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(output int n);
    n = 0;
    rst_n = 1'b1;
    while (!halted && n < 500) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    if (n >= 500) chk("watchdog halt", 32'(n), 32'd0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] p, s;

    // Table: LOAD, ADD, STORE, HALT (R4 R5 R11)
    foreach (VEC[k]) begin
      hold_reset();
      clear_mem();
      mem[0] = ins(3'd1, 1'b0, 12'h100);
      mem[1] = ins(3'd3, 1'b0, 12'h101);
      mem[2] = ins(3'd2, 1'b0, 12'h102);
      mem[3] = ins(3'd0, 1'b0, 12'h000);
      mem[12'h100] = VEC[k][47:32];
      mem[12'h101] = VEC[k][31:16];
      run(n);
      chk("R4 add result", 32'(acc), 32'(VEC[k][15:0]));
      chk("R5 store word", 32'(mem[12'h102]), 32'(VEC[k][15:0]));
      chk("R11 cycle count", 32'(n), 32'd21);
    end

    // R1 reset state and first fetch, R2 fetch timing
    hold_reset();
    chk("R1 pc at reset", 32'(pc), 32'd0);
    chk("R1 acc at reset", 32'(acc), 32'd0);
    chk("R1 strobes at reset", {30'd0, mem_rd, mem_wr}, 32'd0);
    chk("R1 halted at reset", 32'(halted), 32'd0);
    clear_mem();
    mem[0] = ins(3'd0, 1'b0, 12'h000);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 read strobe cycle 2", 32'(mem_rd), 32'd1);
    chk("R1 first fetch address", 32'(mem_addr), 32'd0);
    chk("R2 pc before increment", 32'(pc), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R2 pc incremented", 32'(pc), 32'd1);
    chk("R2 no strobe cycle 3", {30'd0, mem_rd, mem_wr}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R3 halt opcode 000", 32'(halted), 32'd1);

    // R7 indirect load
    hold_reset();
    clear_mem();
    mem[0] = ins(3'd1, 1'b1, 12'h200);
    mem[1] = ins(3'd0, 1'b0, 12'h000);
    mem[12'h200] = 16'hF300;
    mem[12'h300] = 16'hBEEF;
    run(n);
    chk("R7 indirect operand", 32'(acc), 32'h0000BEEF);
    chk("R7 indirect cycles", 32'(n), 32'd12);

    // R6 jump, R11 jump length, R3 field layout
    hold_reset();
    clear_mem();
    mem[0] = ins(3'd4, 1'b0, 12'h050);
    mem[1] = ins(3'd2, 1'b0, 12'h102);
    mem[12'h050] = ins(3'd1, 1'b0, 12'h100);
    mem[12'h051] = ins(3'd0, 1'b0, 12'h000);
    mem[12'h100] = 16'h00A5;
    run(n);
    chk("R6 jump target executed", 32'(acc), 32'h000000A5);
    chk("R6 skipped word untouched", 32'(mem[12'h102]), 32'd0);
    chk("R6 pc after halt", 32'(pc), 32'h052);
    chk("R11 jump four cycles", 32'(n), 32'd13);

    // R9 halt holds
    strobes = 0;
    p = 16'(pc);
    repeat (20) @(negedge clk);
    chk("R9 no strobes after halt", 32'(strobes), 32'd0);
    chk("R9 pc stable", 32'(pc), 32'(p));
    chk("R9 halted stays", 32'(halted), 32'd1);

    // R3 unused opcode 101 is a no-op
    hold_reset();
    clear_mem();
    mem[0] = ins(3'd5, 1'b0, 12'h100);
    mem[1] = ins(3'd0, 1'b0, 12'h000);
    mem[12'h100] = 16'h1111;
    run(n);
    chk("R3 no-op acc", 32'(acc), 32'd0);
    chk("R3 no-op pc", 32'(pc), 32'd2);
    chk("R3 no-op cycles", 32'(n), 32'd7);

    // R8 interrupt taken once with irq held high
    hold_reset();
    clear_mem();
    mem[0] = ins(3'd1, 1'b0, 12'h100);
    mem[1] = ins(3'd2, 1'b0, 12'h102);
    mem[ISR[9:0]]      = ins(3'd3, 1'b0, 12'h101);
    mem[ISR[9:0] + 1]  = ins(3'd0, 1'b0, 12'h000);
    mem[12'h100] = 16'h0010;
    mem[12'h101] = 16'h0005;
    irq = 1'b1;
    run(n);
    irq = 1'b0;
    s = mem[SAVE[9:0]];
    chk("R8 saved return pc", 32'(s), 32'd1);
    chk("R8 routine ran", 32'(acc), 32'h15);
    chk("R8 pc in routine", 32'(pc), 32'(ISR) + 2);
    chk("R8 interrupted word skipped", 32'(mem[12'h102]), 32'd0);
    chk("R8 interrupt cycles", 32'(n), 32'd18);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule